// File: doc/BRIEF.md
# Reset Source Controller with Stop-Acknowledge Supervision

This block merges every system-level reset request of the chip into one system reset output and keeps a sticky record of which request caused the latest reset. Four causes are recognised. A stop-mode entry whose acknowledge handshake never completes is one. A software request that carries the correct key is another. A core lockup indication and a level request from the debug port are the last two. Software, lockup and timeout events are pulses, and each one stretches the system reset to a fixed minimum length. The debug request is a level, and it keeps the system in reset for as long as it stays high.

The stop-mode supervisor counts ticks of a slow low-power time base while a stop request is pending. The time base enters as a one-cycle enable, because both domains are modelled on one clock. If even one module is still missing its acknowledge after the configured number of ticks, the supervisor raises a timeout reset. A separate core reset follows the system reset. The debug port can hold the core in reset after the rest of the chip has been released. The debug-domain reset comes only from the power-on reset, so no system reset ever disturbs the debug logic.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst`, `core_rst` and `dbg_rst` are 1 and `cause` is 0000. At the first clock edge after `rst_n` rises, with no request present, `sys_rst`, `core_rst` and `dbg_rst` go to 0.
- R2: Suppose `stop_req` is 1, some acknowledge is 0 and `sys_rst` is 0. The block counts clock edges that have `lp_tick` = 1. On the edge that carries the TIMEOUT-th such tick (default 2^16 + 1), `sys_rst` rises and `cause` becomes 0001 (bit 0 = stop-acknowledge timeout).
- R3: A single missing bit of `stop_ack` is enough to cause the timeout. When every bit of `stop_ack` is 1, the count is held at zero and no timeout occurs.
- R4: Dropping `stop_req` before expiry clears the tick count, so a later request starts counting from zero.
- R5: `sw_req` = 1 with `sw_key` = 0x05FA while `sys_rst` is 0 asserts `sys_rst` on the next edge and sets `cause` to 0010 (bit 1 = software).
- R6: `sw_req` with any other key is ignored. `sys_rst` stays 0 and `cause` is unchanged.
- R7: `lockup` = 1 while `sys_rst` is 0 asserts `sys_rst` on the next edge and sets `cause` to 0100 (bit 2 = lockup).
- R8: A pulsed cause (timeout, software, lockup) holds `sys_rst` at 1 for exactly MIN_HOLD clock cycles (default 16). Pulsed requests that arrive while `sys_rst` is 1 are ignored.
- R9: `sys_rst` is 1 from the edge after `dbg_sys_req` goes to 1 until the edge after it returns to 0 (or until a running minimum hold ends, if that is later). A rising `dbg_sys_req` sets `cause` to 1000 (bit 3 = debug).
- R10: `core_rst` is 1 whenever `sys_rst` is 1. If `dbg_core_hold` is 1 when `sys_rst` falls, `core_rst` stays 1 until the edge after `dbg_core_hold` returns to 0.
- R11: `dbg_rst` stays 0 after power-on release, whatever system resets occur.
- R12: `cause` is one-hot or zero, and it keeps its value until a new cause is recorded. When causes coincide, the priority is debug, then lockup, then software, then timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the low-power time base is modelled as an enable on it |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| lp_tick | input | 1 | One-cycle pulse per low-power clock period |
| stop_req | input | 1 | Stop-mode entry request, held while pending |
| stop_ack | input | NUM_MODS | Per-module stop acknowledge, 1 = acknowledged |
| sw_req | input | 1 | Software reset request strobe |
| sw_key | input | 16 | Key accompanying the software request |
| lockup | input | 1 | Core lockup indication |
| dbg_sys_req | input | 1 | Debug-port system reset request level |
| dbg_core_hold | input | 1 | Debug-port request to keep the core in reset |
| sys_rst | output | 1 | System reset, active high |
| core_rst | output | 1 | Core reset, active high |
| dbg_rst | output | 1 | Debug-domain reset, active high, power-on only |
| cause | output | 4 | Sticky one-hot reset cause: bit 3 debug, bit 2 lockup, bit 1 software, bit 0 stop timeout |

## Verification
The assertions assume the following about the inputs:
- Inputs change only between clock edges.
- `sw_req` and `lockup` are meaningful as single-cycle events.
- `lp_tick` is a strobe, not a level held for many cycles.

The stimulus drives every input on the falling edge. It pulses `lp_tick` on every other cycle and keeps pulsed requests one cycle wide, except where a test makes causes coincide on purpose. It shortens the timeout through a parameter so that both expiry and near-expiry stay reachable. It also injects requests while a reset is already running, so that the rule for ignored requests is exercised.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
   localparam int SRC_N = 4;

   typedef enum logic [1:0] {
      SRC_STOP = 2'd0,
      SRC_SW   = 2'd1,
      SRC_LOCK = 2'd2,
      SRC_DBG  = 2'd3
   } src_e;

   typedef logic [SRC_N-1:0] cause_t;
endpackage

// File: rtl/rsc_stop_watch.sv
module rsc_stop_watch #(
   parameter int NUM_MODS = 4,
   parameter int TIMEOUT  = 65537
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lp_tick,
   input  logic                stop_req,
   input  logic [NUM_MODS-1:0] stop_ack,
   input  logic                blocked,
   output logic                expire
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic             all_ack;
   logic             pending;
   logic [CNT_W-1:0] cnt_q;

   initial begin
      assert (NUM_MODS >= 1) else $error("NUM_MODS must be at least 1");
      assert (TIMEOUT >= 2)  else $error("TIMEOUT must be at least 2");
   end

   generate
      if (NUM_MODS == 1) begin : g_single
         assign all_ack = stop_ack[0];
      end else begin : g_multi
         assign all_ack = &stop_ack;
      end
   endgenerate

   assign pending = stop_req & ~all_ack & ~blocked;
   assign expire  = pending & lp_tick & (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!pending || expire) begin
         cnt_q <= '0;
      end else if (lp_tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && all_ack) |=> (cnt_q == '0));
endmodule

// File: rtl/rsc_cause_sel.sv
module rsc_cause_sel
   import rsc_pkg::*;
(
   input  cause_t evt,
   output cause_t win
);
   genvar gi;
   generate
      for (gi = 0; gi < SRC_N; gi++) begin : g_pri
         if (gi == SRC_N - 1) begin : g_top
            assign win[gi] = evt[gi];
         end else begin : g_low
            assign win[gi] = evt[gi] & ~(|evt[SRC_N-1:gi+1]);
         end
      end
   endgenerate
endmodule

// File: rtl/rsc_hold_gen.sv
module rsc_hold_gen #(
   parameter int MIN_HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_evt,
   input  logic dbg_req,
   input  logic core_hold,
   output logic sys_rst,
   output logic core_rst
);
   localparam int HOLD_W = $clog2(MIN_HOLD + 1);
   localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(MIN_HOLD);

   logic [HOLD_W-1:0] hold_q;
   logic [HOLD_W-1:0] hold_d;
   logic              sys_d;

   initial begin
      assert (MIN_HOLD >= 1) else $error("MIN_HOLD must be at least 1");
   end

   always_comb begin
      if (pulse_evt)
         hold_d = HOLD_LOAD;
      else if (hold_q != '0)
         hold_d = hold_q - 1'b1;
      else
         hold_d = hold_q;
      sys_d = dbg_req | (hold_d != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q   <= '0;
         sys_rst  <= 1'b1;
         core_rst <= 1'b1;
      end else begin
         hold_q   <= hold_d;
         sys_rst  <= sys_d;
         core_rst <= sys_d | (core_rst & core_hold);
      end
   end

   // R8
   pulse_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_evt |=> sys_rst);
   // R10
   core_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst && core_hold) |=> core_rst);
   // R10
   core_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst |-> core_rst);
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
   import rsc_pkg::*;
#(
   parameter int          NUM_MODS = 4,
   parameter int          TIMEOUT  = 65537,
   parameter int          MIN_HOLD = 16,
   parameter logic [15:0] SW_KEY   = 16'h05FA
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lp_tick,
   input  logic                stop_req,
   input  logic [NUM_MODS-1:0] stop_ack,
   input  logic                sw_req,
   input  logic [15:0]         sw_key,
   input  logic                lockup,
   input  logic                dbg_sys_req,
   input  logic                dbg_core_hold,
   output logic                sys_rst,
   output logic                core_rst,
   output logic                dbg_rst,
   output logic [3:0]          cause
);
   logic   expire;
   logic   sw_ok;
   logic   lock_ok;
   logic   dbg_q;
   logic   dbg_edge;
   logic   pulse_evt;
   cause_t evt;
   cause_t win;
   cause_t cause_q;

   rsc_stop_watch #(
      .NUM_MODS (NUM_MODS),
      .TIMEOUT  (TIMEOUT)
   ) u_watch (
      .clk      (clk),
      .rst_n    (rst_n),
      .lp_tick  (lp_tick),
      .stop_req (stop_req),
      .stop_ack (stop_ack),
      .blocked  (sys_rst),
      .expire   (expire)
   );

   assign sw_ok     = sw_req & (sw_key == SW_KEY) & ~sys_rst;
   assign lock_ok   = lockup & ~sys_rst;
   assign dbg_edge  = dbg_sys_req & ~dbg_q;
   assign pulse_evt = expire | sw_ok | lock_ok;

   always_comb begin
      evt           = '0;
      evt[SRC_STOP] = expire;
      evt[SRC_SW]   = sw_ok;
      evt[SRC_LOCK] = lock_ok;
      evt[SRC_DBG]  = dbg_edge;
   end

   rsc_cause_sel u_sel (
      .evt (evt),
      .win (win)
   );

   rsc_hold_gen #(
      .MIN_HOLD (MIN_HOLD)
   ) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_evt (pulse_evt),
      .dbg_req   (dbg_sys_req),
      .core_hold (dbg_core_hold),
      .sys_rst   (sys_rst),
      .core_rst  (core_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbg_q   <= 1'b0;
         cause_q <= '0;
         dbg_rst <= 1'b1;
      end else begin
         dbg_q   <= dbg_sys_req;
         dbg_rst <= 1'b0;
         if (|evt)
            cause_q <= win;
      end
   end

   assign cause = cause_q;

   // R12
   cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cause));
   // R9
   dbg_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_sys_req |=> sys_rst);
   // R6
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_req && sw_key != SW_KEY && !lockup && !dbg_edge && !expire) |=> $stable(cause));
   // R2
   expire_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (sys_rst && cause != '0));
   // R11
   dbg_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dbg_rst |=> !dbg_rst);
endmodule

// File: tb/tb_rst_src_ctrl.sv
module tb_rst_src_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NM   = 4;
   localparam int TO   = 40;
   localparam int HOLD = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lp_tick = 1'b0;
   logic          stop_req = 1'b0;
   logic [NM-1:0] stop_ack = '1;
   logic          sw_req = 1'b0;
   logic [15:0]   sw_key = 16'h0000;
   logic          lockup = 1'b0;
   logic          dbg_sys_req = 1'b0;
   logic          dbg_core_hold = 1'b0;
   logic          sys_rst, core_rst, dbg_rst;
   logic [3:0]    cause;

   int n_chk = 0;
   int n_bad = 0;

   rst_src_ctrl #(.NUM_MODS(NM), .TIMEOUT(TO), .MIN_HOLD(HOLD)) dut (
      .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .stop_req(stop_req),
      .stop_ack(stop_ack), .sw_req(sw_req), .sw_key(sw_key), .lockup(lockup),
      .dbg_sys_req(dbg_sys_req), .dbg_core_hold(dbg_core_hold),
      .sys_rst(sys_rst), .core_rst(core_rst), .dbg_rst(dbg_rst), .cause(cause));

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) lp_tick = ~lp_tick;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // behavioural reference model
   int m_ticks;
   int m_hold;
   bit m_sys, m_core, m_dbgrst, m_dbgprev;
   int m_cause;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ticks = 0; m_hold = 0; m_sys = 1; m_core = 1; m_dbgrst = 1;
         m_dbgprev = 0; m_cause = 0;
      end else begin
         bit waiting, timed_out, sw_hit, lk_hit, dbg_hit, was_core;
         waiting = stop_req && (stop_ack != '1) && !m_sys;
         timed_out = 0;
         if (!waiting) m_ticks = 0;
         else if (lp_tick) begin
            m_ticks = m_ticks + 1;
            if (m_ticks == TO) begin timed_out = 1; m_ticks = 0; end
         end
         sw_hit  = !m_sys && sw_req && sw_key == 16'h05FA;
         lk_hit  = !m_sys && lockup;
         dbg_hit = dbg_sys_req && !m_dbgprev;
         if (dbg_hit) m_cause = 8;
         else if (lk_hit) m_cause = 4;
         else if (sw_hit) m_cause = 2;
         else if (timed_out) m_cause = 1;
         if (sw_hit || lk_hit || timed_out) m_hold = HOLD;
         else if (m_hold > 0) m_hold = m_hold - 1;
         was_core = m_core;
         m_sys = dbg_sys_req || (m_hold > 0);
         m_core = m_sys || (was_core && dbg_core_hold);
         m_dbgprev = dbg_sys_req;
         m_dbgrst = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(sys_rst == m_sys,   "R8 sys_rst vs model",  sys_rst, m_sys);
         chk(core_rst == m_core, "R10 core_rst vs model", core_rst, m_core);
         chk(dbg_rst == m_dbgrst, "R11 dbg_rst vs model", dbg_rst, m_dbgrst);
         chk(cause == 4'(m_cause), "R12 cause vs model", cause, m_cause);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      bit seen;
      repeat (4) @(negedge clk);
      chk(sys_rst == 1 && core_rst == 1 && dbg_rst == 1, "R1 in reset", sys_rst, 1);
      chk(cause == 0, "R1 cause in reset", cause, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sys_rst == 0 && core_rst == 0, "R1 release", sys_rst, 0);
      chk(dbg_rst == 0, "R1 dbg_rst release", dbg_rst, 0);
      repeat (3) @(negedge clk);

      // wrong key
      sw_req = 1; sw_key = 16'h05FB;
      @(negedge clk); sw_req = 0;
      repeat (2) @(negedge clk);
      chk(sys_rst == 0, "R6 bad key no reset", sys_rst, 0);
      chk(cause == 0, "R6 bad key cause", cause, 0);

      // correct key, count hold, lockup injected during hold
      sw_req = 1; sw_key = 16'h05FA;
      @(negedge clk); sw_req = 0;
      chk(sys_rst == 1, "R5 sw reset", sys_rst, 1);
      chk(cause == 4'b0010, "R5 sw cause", cause, 2);
      n = 0;
      while (sys_rst && n < 100) begin
         n++;
         lockup = (n == 5);
         @(negedge clk);
      end
      lockup = 0;
      chk(n == HOLD, "R8 hold length", n, HOLD);
      chk(cause == 4'b0010, "R8 request during reset ignored", cause, 2);
      repeat (3) @(negedge clk);

      // lockup
      lockup = 1; @(negedge clk); lockup = 0;
      chk(sys_rst == 1 && cause == 4'b0100, "R7 lockup", cause, 4);
      chk(dbg_rst == 0, "R11 dbg_rst during reset", dbg_rst, 0);
      repeat (HOLD + 3) @(negedge clk);

      // stop with all acks
      stop_req = 1; stop_ack = '1;
      repeat (4 * TO) @(negedge clk);
      chk(sys_rst == 0, "R3 all acks no timeout", sys_rst, 0);

      // R4 partial windows
      stop_ack = 4'b1011;
      repeat (TO) @(negedge clk);
      stop_req = 0; @(negedge clk); @(negedge clk); stop_req = 1;
      repeat (TO) @(negedge clk);
      chk(sys_rst == 0 && cause == 4'b0100, "R4 restart from zero", sys_rst, 0);
      stop_req = 0; repeat (3) @(negedge clk);

      // timeout with one missing ack
      stop_req = 1; stop_ack = 4'b1101;
      seen = 0;
      for (int i = 0; i < 4 * TO && !seen; i++) begin
         @(negedge clk);
         if (sys_rst) seen = 1;
      end
      stop_req = 0; stop_ack = '1;
      chk(seen, "R2 timeout reset", seen, 1);
      chk(cause == 4'b0001, "R3 single missing ack cause", cause, 1);
      repeat (HOLD + 3) @(negedge clk);

      // debug level request
      dbg_sys_req = 1;
      repeat (30) @(negedge clk);
      chk(sys_rst == 1 && cause == 4'b1000, "R9 debug held", cause, 8);
      dbg_sys_req = 0; @(negedge clk);
      chk(sys_rst == 0 && core_rst == 0, "R9 debug release", sys_rst, 0);

      // core hold
      dbg_core_hold = 1; dbg_sys_req = 1;
      repeat (5) @(negedge clk);
      dbg_sys_req = 0;
      repeat (3) @(negedge clk);
      chk(sys_rst == 0 && core_rst == 1, "R10 core held", core_rst, 1);
      dbg_core_hold = 0; @(negedge clk);
      chk(core_rst == 0, "R10 core released", core_rst, 0);
      repeat (2) @(negedge clk);

      // priority
      lockup = 1; sw_req = 1; sw_key = 16'h05FA;
      @(negedge clk); lockup = 0; sw_req = 0;
      chk(cause == 4'b0100, "R12 lockup beats software", cause, 4);
      repeat (HOLD + 3) @(negedge clk);
      dbg_sys_req = 1; lockup = 1; sw_req = 1;
      @(negedge clk); lockup = 0; sw_req = 0;
      chk(cause == 4'b1000, "R12 debug beats all", cause, 8);
      dbg_sys_req = 0;
      repeat (HOLD + 3) @(negedge clk);
      chk(cause == 4'b1000, "R12 cause sticky", cause, 8);
      finish_run();
   end
endmodule